// File: doc/BRIEF.md
# Split-Mode 32-Entry Lookup Logic Block

A configurable logic block built around one 32-entry lookup table with two table outputs, F and G, and two flip-flops, QX and QY. Every table address bit is picked by its own 3-bit selector from eight candidates: the five block inputs A to E, the two flip-flop outputs fed back, and a constant zero. A 2-bit mode field decides how the table is used. It can act as one 5-input function, with F equal to G. It can act as two separate 4-input functions, with F reading the lower half and G the upper half. Or the two halves can be joined by a 2:1 selection driven by one more candidate, so that some 6- and 7-variable functions fit.

Each flip-flop loads either its own data-in pin or its table output (F for QX, G for QY) when the shared clock enable is high. Two things clear both flip-flops at once: the asynchronous reset-direct input and the global reset. The outputs X and Y each pass either the table output or the flip-flop. The table read is a fixed multiplexer path, so its delay does not depend on the programmed function.

The configuration is a 65-bit frame that enters one bit per cycle on a valid/ready serial stream. `cfg_ready` is low during reset and high at all other times, so back-pressure only happens in reset. The sender may drop `cfg_valid` for any number of cycles, and no bit is taken on those cycles. The frame is collected in a shadow register. It replaces the active configuration all at once, on the edge that accepts its last bit.

Top module: `clb_split_lut`

## Requirements
- R1: A configuration bit is accepted on a rising clock edge where both `cfg_valid` and `cfg_ready` are high. Frame bit 0 goes first. Cycles with `cfg_valid` low are ignored, and `cfg_ready` is low in reset and high after it. The frame holds: table entry n at bit n (bits 0-31), mode at bits 33:32, F-half selector i at bits 36+3i:34+3i, G-half selector i at bits 48+3i:46+3i, top selector at 60:58, QX source at 61, QY source at 62, X output select at 63, and Y output select at 64.
- R2: The active configuration changes only on the edge that accepts the 65th bit of a frame. Until then, a partly shifted frame has no effect on any output.
- R3: In mode 00 the table address is {top, F3, F2, F1, F0} (top is the MSB), and F = G = table[address]. Mode 11 behaves like mode 00.
- R4: In mode 01, F = table[{0, F3..F0}] and G = table[{1, G3..G0}].
- R5: In mode 10, F and G both equal table[{1, G3..G0}] when the top-selected candidate is 1, and table[{0, F3..F0}] when it is 0.
- R6: Selector codes 0 to 4 pick inputs A to E (`vars_in` bits 0 to 4). Code 5 picks QX, code 6 picks QY, and code 7 picks a constant 0.
- R7: When `ce` is high, the flip-flops load on the rising clock edge. When `ce` is low, they hold their value.
- R8: Setting `rd` high clears QX and QY at once, without waiting for the clock, and it wins over `ce`. `rst_n` low also clears the flip-flops and the configuration.
- R9: Source bit 0 loads the flip-flop from its data-in pin. Source bit 1 loads QX from F and QY from G.
- R10: Output select 0 drives X with F (and Y with G). Output select 1 drives X with QX (and Y with QY).
- R11: On the commit edge, a flip-flop that loads from the table takes the value the table gave under the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| cfg_valid | input | 1 | Configuration bit valid |
| cfg_ready | output | 1 | Ready to take a configuration bit |
| cfg_bit | input | 1 | Serial configuration bit |
| vars_in | input | 5 | Block inputs A (bit 0) to E (bit 4) |
| din_x | input | 1 | Data-in for QX |
| din_y | input | 1 | Data-in for QY |
| ce | input | 1 | Flip-flop clock enable |
| rd | input | 1 | Reset direct, active high, asynchronous |
| f_out | output | 1 | Table output F |
| g_out | output | 1 | Table output G |
| qx | output | 1 | Flip-flop QX |
| qy | output | 1 | Flip-flop QY |
| x_out | output | 1 | Output X (F or QX) |
| y_out | output | 1 | Output Y (G or QY) |

## Verification
A configuration commit and a flip-flop load can happen on the same edge. The question is which table contents the flip-flop sees. The bench keeps `ce` high while it loads a frame that changes every table entry from 1 to 0. At the commit edge, QX must take the old value, 1. This is then read through X after the new output select has routed QX to X. A second collision is `rd` and `ce` both high. `rd` is raised between clock edges with `ce` and data-in high, and QX must be cleared right away and stay clear across the next edge.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int ADDR_W   = 5;
  localparam int LUT_BITS = 1 << ADDR_W;
  localparam int HALF_W   = ADDR_W - 1;
  localparam int NUM_PINS = 5;
  localparam int SEL_W    = 3;
  localparam int NCAND    = 1 << SEL_W;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_MUX    = 2'b10,
    MODE_RSVD   = 2'b11
  } mode_e;

  // Packed MSB first: table bits land at frame bits 0 upward.
  typedef struct packed {
    logic                          y_osel;
    logic                          x_osel;
    logic                          y_src;
    logic                          x_src;
    logic [SEL_W-1:0]              sel_top;
    logic [HALF_W-1:0][SEL_W-1:0]  sel_g;
    logic [HALF_W-1:0][SEL_W-1:0]  sel_f;
    mode_e                         mode;
    logic [LUT_BITS-1:0]           lut;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/clb_cfg_loader.sv
module clb_cfg_loader
  import clb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_valid,
  input  logic cfg_bit,
  output logic cfg_ready,
  output cfg_t active
);
  localparam int CNT_W = $clog2(CFG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_W - 1);

  logic [CFG_W-1:0] shadow;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic [CFG_W-1:0] next_shadow;

  assign accept      = cfg_valid & cfg_ready;
  assign next_shadow = {cfg_bit, shadow[CFG_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ready <= 1'b0;
      shadow    <= '0;
      cnt       <= '0;
      active    <= '0;
    end else begin
      cfg_ready <= 1'b1;
      if (accept) begin
        shadow <= next_shadow;
        if (cnt == LAST) begin
          cnt    <= '0;
          active <= cfg_t'(next_shadow);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clb_lut_core.sv
module clb_lut_core
  import clb_pkg::*;
(
  input  cfg_t                cfg,
  input  logic [NUM_PINS-1:0] vars_in,
  input  logic                qx,
  input  logic                qy,
  output logic                f_o,
  output logic                g_o
);
  logic [NCAND-1:0]  cand;
  logic [HALF_W-1:0] af;
  logic [HALF_W-1:0] ag;
  logic              top_v;
  logic              lo_bit;
  logic              hi_bit;

  for (genvar k = 0; k < NCAND; k++) begin : g_cand
    if (k < NUM_PINS) begin : g_pin
      assign cand[k] = vars_in[k];
    end else if (k == NUM_PINS) begin : g_qx
      assign cand[k] = qx;
    end else if (k == NUM_PINS + 1) begin : g_qy
      assign cand[k] = qy;
    end else begin : g_zero
      assign cand[k] = 1'b0;
    end
  end

  for (genvar i = 0; i < HALF_W; i++) begin : g_addr
    assign af[i] = cand[cfg.sel_f[i]];
    assign ag[i] = cand[cfg.sel_g[i]];
  end

  assign top_v  = cand[cfg.sel_top];
  assign lo_bit = cfg.lut[{1'b0, af}];
  assign hi_bit = cfg.lut[{1'b1, ag}];

  always_comb begin
    case (cfg.mode)
      MODE_DUAL: begin
        f_o = lo_bit;
        g_o = hi_bit;
      end
      MODE_MUX: begin
        f_o = top_v ? hi_bit : lo_bit;
        g_o = f_o;
      end
      default: begin
        f_o = cfg.lut[{top_v, af}];
        g_o = f_o;
      end
    endcase
  end
endmodule

// File: rtl/clb_flop_bank.sv
module clb_flop_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic         ce,
  input  logic [N-1:0] din,
  input  logic [N-1:0] tbl,
  input  logic [N-1:0] src,
  output logic [N-1:0] q
);
  for (genvar j = 0; j < N; j++) begin : g_ff
    logic d_sel;
    assign d_sel = src[j] ? tbl[j] : din[j];

    always_ff @(posedge clk or negedge rst_n or posedge rd) begin
      if (!rst_n)   q[j] <= 1'b0;
      else if (rd)  q[j] <= 1'b0;
      else if (ce)  q[j] <= d_sel;
    end
  end
endmodule

// File: rtl/clb_split_lut.sv
module clb_split_lut
  import clb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic                cfg_bit,
  input  logic [NUM_PINS-1:0] vars_in,
  input  logic                din_x,
  input  logic                din_y,
  input  logic                ce,
  input  logic                rd,
  output logic                f_out,
  output logic                g_out,
  output logic                qx,
  output logic                qy,
  output logic                x_out,
  output logic                y_out
);
  cfg_t       active_cfg;
  logic [1:0] q_pair;

  clb_cfg_loader u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_bit   (cfg_bit),
    .cfg_ready (cfg_ready),
    .active    (active_cfg)
  );

  clb_lut_core u_core (
    .cfg     (active_cfg),
    .vars_in (vars_in),
    .qx      (qx),
    .qy      (qy),
    .f_o     (f_out),
    .g_o     (g_out)
  );

  clb_flop_bank #(.N(2)) u_flops (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (rd),
    .ce    (ce),
    .din   ({din_y, din_x}),
    .tbl   ({g_out, f_out}),
    .src   ({active_cfg.y_src, active_cfg.x_src}),
    .q     (q_pair)
  );

  assign qx    = q_pair[0];
  assign qy    = q_pair[1];
  assign x_out = active_cfg.x_osel ? qx : f_out;
  assign y_out = active_cfg.y_osel ? qy : g_out;
endmodule

// File: rtl/clb_split_lut_chk.sv
module clb_split_lut_chk
  import clb_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cfg_valid,
  input logic cfg_ready,
  input logic ce,
  input logic rd,
  input logic din_x,
  input logic f_out,
  input logic g_out,
  input logic qx,
  input logic qy,
  input cfg_t active
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cfg_ready);

  p_commit_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_ready) |=> $stable(active));

  p_single_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active.mode == MODE_SINGLE || active.mode == MODE_RSVD) |-> (f_out == g_out));

  p_mux_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active.mode == MODE_MUX) |-> (f_out == g_out));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || rd)
    (!ce) |=> ($stable(qx) && $stable(qy)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (!qx && !qy));

  p_din_load_r9: assert property (@(posedge clk) disable iff (!rst_n || rd)
    (ce && !active.x_src) |=> (qx == $past(din_x)));
endmodule

bind clb_split_lut clb_split_lut_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .ce        (ce),
  .rd        (rd),
  .din_x     (din_x),
  .f_out     (f_out),
  .g_out     (g_out),
  .qx        (qx),
  .qy        (qy),
  .active    (active_cfg)
);

// File: tb/clb_split_lut_test.sv
module clb_split_lut_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_bit = 1'b0;
  logic [4:0] vars_in = '0;
  logic       din_x = 1'b0;
  logic       din_y = 1'b0;
  logic       ce = 1'b0;
  logic       rd = 1'b0;
  logic       cfg_ready, f_out, g_out, qx, qy, x_out, y_out;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  clb_split_lut uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .vars_in(vars_in), .din_x(din_x), .din_y(din_y),
    .ce(ce), .rd(rd), .f_out(f_out), .g_out(g_out), .qx(qx), .qy(qy),
    .x_out(x_out), .y_out(y_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Frame layout as stated in R1.
  function automatic logic [64:0] mk(input logic [31:0] lut, input logic [1:0] mode,
                                     input logic [11:0] sf, input logic [11:0] sg,
                                     input logic [2:0] top, input logic xs, input logic ys,
                                     input logic xo, input logic yo);
    return {yo, xo, ys, xs, top, sg, sf, mode, lut};
  endfunction

  function automatic logic [1:0] model(input logic [64:0] fr, input logic [4:0] v,
                                       input logic qxv, input logic qyv);
    logic [7:0] cand;
    logic [3:0] af, ag;
    logic       t, f, g;
    cand = {1'b0, qyv, qxv, v};
    for (int i = 0; i < 4; i++) begin
      af[i] = cand[fr[34+3*i +: 3]];
      ag[i] = cand[fr[46+3*i +: 3]];
    end
    t = cand[fr[60:58]];
    case (fr[33:32])
      2'b01: begin f = fr[{1'b0, af}]; g = fr[{1'b1, ag}]; end
      2'b10: begin f = t ? fr[{1'b1, ag}] : fr[{1'b0, af}]; g = f; end
      default: begin f = fr[{t, af}]; g = f; end
    endcase
    return {g, f};
  endfunction

  task automatic load(input logic [64:0] fr, input int gap, input bit hold_chk,
                      input logic hold_x);
    for (int i = 0; i < 65; i++) begin
      if (gap > 0 && (i % gap) == 0) begin
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_bit = ~fr[i];
      end
      @(negedge clk);
      if (hold_chk && i == 64) chk("R2 partial frame hold", x_out, hold_x);
      cfg_valid = 1'b1;
      cfg_bit = fr[i];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic sweep(input logic [64:0] fr, input string req);
    logic [1:0] e;
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      vars_in = v[4:0];
      #1;
      e = model(fr, v[4:0], 1'b0, 1'b0);
      chk(req, {f_out, g_out, x_out, y_out}, {e[0], e[1], e[0], e[1]});
    end
  endtask

  task automatic t_reset;
    chk("R1 ready low in reset", cfg_ready, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", cfg_ready, 1'b1);
    chk("R8 reset state", {x_out, y_out, qx, qy}, 4'b0);
  endtask

  task automatic t_single;
    logic [64:0] fr;
    rd = 1'b1;
    fr = mk(32'hA5C3_96E1, 2'b00, {3'd1, 3'd3, 3'd0, 3'd4}, 12'd0, 3'd2, 0, 0, 0, 0);
    load(fr, 0, 0, 1'b0);
    sweep(fr, "R3 R6 single mode");
  endtask

  task automatic t_dual;
    logic [64:0] fr;
    fr = mk(32'h1234_F0E7, 2'b01, {3'd3, 3'd2, 3'd1, 3'd0}, {3'd0, 3'd7, 3'd3, 3'd4},
            3'd0, 0, 0, 0, 0);
    load(fr, 0, 0, 1'b0);
    sweep(fr, "R4 R6 dual mode");
  endtask

  task automatic t_mux;
    logic [64:0] fr;
    fr = mk(32'h6C1B_8E35, 2'b10, {3'd3, 3'd2, 3'd1, 3'd0}, {3'd1, 3'd3, 3'd2, 3'd0},
            3'd4, 0, 0, 0, 0);
    load(fr, 0, 0, 1'b0);
    sweep(fr, "R5 mux mode");
  endtask

  task automatic t_rsvd;
    logic [64:0] fr;
    fr = mk(32'h0F0F_3355, 2'b11, {3'd0, 3'd1, 3'd2, 3'd3}, 12'hFFF, 3'd4, 0, 0, 0, 0);
    load(fr, 0, 0, 1'b0);
    sweep(fr, "R3 mode 11 as single");
  endtask

  task automatic t_feedback;
    logic [64:0] fr;
    logic [1:0]  e;
    // F address bit 0 from QY, top bit from QX; entry pattern differs by both.
    fr = mk(32'hFF00_F0AA, 2'b00, {3'd2, 3'd1, 3'd0, 3'd6}, 12'd0, 3'd5, 0, 0, 0, 0);
    load(fr, 0, 0, 1'b0);
    @(negedge clk); rd = 1'b0; vars_in = 5'b00101; din_x = 1'b1; din_y = 1'b1; ce = 1'b1;
    @(negedge clk);
    chk("R7 load QX/QY from data-in", {qx, qy}, 2'b11);
    e = model(fr, 5'b00101, 1'b1, 1'b1);
    chk("R6 flop feedback address", f_out, e[0]);
    ce = 1'b0; din_x = 1'b0; din_y = 1'b0;
    @(negedge clk);
    chk("R7 hold with ce low", {qx, qy}, 2'b11);
    ce = 1'b1; din_x = 1'b1; din_y = 1'b1;
    #1 rd = 1'b1;
    #1 chk("R8 rd clears without clock", {qx, qy}, 2'b00);
    @(negedge clk);
    chk("R8 rd wins over ce", {qx, qy}, 2'b00);
    e = model(fr, 5'b00101, 1'b0, 1'b0);
    chk("R6 feedback after clear", f_out, e[0]);
    rd = 1'b0; ce = 1'b0;
  endtask

  task automatic t_src_osel;
    logic [64:0] fr;
    logic [1:0]  e;
    fr = mk(32'h8421_1248, 2'b01, {3'd3, 3'd2, 3'd1, 3'd0}, {3'd3, 3'd2, 3'd1, 3'd0},
            3'd0, 1, 1, 1, 1);
    load(fr, 0, 0, 1'b0);
    @(negedge clk); vars_in = 5'd3; din_x = 1'b0; din_y = 1'b0; ce = 1'b1;
    e = model(fr, 5'd3, 1'b0, 1'b0);
    @(negedge clk);
    ce = 1'b0;
    chk("R9 QX/QY from table", {qx, qy}, {e[0], e[1]});
    vars_in = 5'd0;
    #1;
    chk("R10 X/Y show flops", {x_out, y_out}, {e[0], e[1]});
    e = model(fr, 5'd0, qx, qy);
    chk("R10 F/G still live", {f_out, g_out}, {e[0], e[1]});
  endtask

  task automatic t_partial;
    logic [64:0] old_fr, fr;
    logic [1:0]  e;
    rd = 1'b1;
    old_fr = mk(32'hFFFF_FFFF, 2'b00, 12'd0, 12'd0, 3'd0, 0, 0, 0, 0);
    load(old_fr, 0, 0, 1'b0);
    fr = mk(32'h0000_0000, 2'b00, 12'd0, 12'd0, 3'd0, 0, 0, 0, 0);
    load(fr, 3, 1, 1'b1);
    #1 chk("R2 new frame takes effect", x_out, 1'b0);
    fr = mk(32'h9999_6666, 2'b01, {3'd3, 3'd2, 3'd1, 3'd0}, {3'd0, 3'd1, 3'd2, 3'd3},
            3'd0, 0, 0, 0, 0);
    load(fr, 5, 0, 1'b0);
    @(negedge clk); vars_in = 5'd6; #1;
    e = model(fr, 5'd6, 1'b0, 1'b0);
    chk("R1 gaps with valid low ignored", {f_out, g_out}, {e[0], e[1]});
    rd = 1'b0;
  endtask

  task automatic t_commit_collide;
    logic [64:0] fr;
    fr = mk(32'hFFFF_FFFF, 2'b00, 12'd0, 12'd0, 3'd0, 1, 0, 0, 0);
    load(fr, 0, 0, 1'b0);
    @(negedge clk); ce = 1'b1;
    fr = mk(32'h0000_0000, 2'b00, 12'd0, 12'd0, 3'd0, 1, 0, 1, 0);
    load(fr, 0, 0, 1'b0);
    ce = 1'b0;
    #1;
    chk("R11 commit edge uses old table", x_out, 1'b1);
    chk("R11 new table active", f_out, 1'b0);
    @(negedge clk); ce = 1'b1;
    @(negedge clk); ce = 1'b0;
    chk("R11 next load uses new table", x_out, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_mux();
    t_rsvd();
    t_feedback();
    t_src_osel();
    t_partial();
    t_commit_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule